// File: doc/BRIEF.md
# Lockable Wiper Position Register with Serial Target Interface

This block is the digital side of a 64-step resistor ladder. It holds a 6-bit tap code and drives it onto `wiper_o`. A host reaches it as a two-wire serial bus target with a 7-bit address. A host may overwrite the code and read it back as often as it likes. A write that also sets the lock flag starts a one-time burn phase. That phase is modelled as a busy counter of `BURN_CYCLES` clocks. When it ends, the code is stored in a fuse bank and the output is frozen for good.

The fuse bank is the only state that the synchronous reset leaves alone. After a burn, every reset reloads the stored code instead of the midscale preset. A read returns the tap code with two status bits above it. These bits tell the host whether the part is unlocked, locked correctly, or locked with a code that differs from the register at the end of the burn. The lowest address bit comes from a pin, so two instances can share one bus.

The bus lines are oversampled by the system clock. The data line is open-drain: the block only ever asks for it to be pulled low, through `sda_oe`.

Top module: `wiper_otp_target`

## Requirements
- R1: While no burn has completed, reset loads code 0x20 and a read returns status 00.
- R2: A write frame is the address byte with R/W=0, an instruction byte, then a data byte whose bits 5:0 become the new code, visible on `wiper_o` after the data byte. The target acknowledges every byte, and repeated writes are all accepted while unlocked.
- R3: A read frame is the address byte with R/W=1 followed by one byte sent MSB first, laid out as {status[1:0], code[5:0]}. The status is 00 when unlocked, 11 when the lock succeeded and 10 when it failed; 01 never occurs.
- R4: The target answers only address {6'b010110, addr_sel}. Any other address is not acknowledged and changes nothing.
- R5: A write whose instruction bit 6 is 1 stores its data byte as the new code and starts a burn lasting `BURN_CYCLES` clocks. At the end, the captured code is kept in the fuse bank and the status becomes 11 if the register still holds it.
- R6: Once the fuse bank is written, writes are still acknowledged but `wiper_o` never changes.
- R7: After a completed burn, reset loads the fused code and keeps the status instead of loading 0x20.
- R8: While a burn runs, further lock requests are ignored but plain code writes still land in the register. If the register differs from the captured code when the burn ends, the status becomes 10 and `wiper_o` shows the captured code.
- R9: `sda_oe` is low whenever the target is idle. START and STOP are recognised only as data-line edges while the clock line is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset; fuse bank is unaffected |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel | input | 1 | Selects the lowest bit of the target address |
| sda_oe | output | 1 | High asks the data line to be pulled low |
| wiper_o | output | 6 | Current tap code |

## Verification
The assertions assume that reset is held for several clocks and is never asserted during a burn. The busy-end check relies on this, because a burn cut short by reset would look like an unfused fall of busy. They also assume that bus edges come slowly enough for the synchroniser to see every level. To meet this, the stimulus holds each bus line for at least five system clocks between changes, never changes the data line in the same step as the clock line, and applies reset only between frames while no burn is active.

// File: rtl/wiper_otp_pkg.sv
// Shared definitions for the lockable wiper target.
// Assumes a fixed 6-bit tap code so that status plus code fill one byte.
package wiper_otp_pkg;
    localparam int WIPER_W = 6;
    localparam int BYTE_W  = 8;
    typedef logic [WIPER_W-1:0] code_t;

    // Serial target states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK
    } tgt_state_t;
endpackage

// File: rtl/bus_sync.sv
// Multi-stage synchroniser for the asynchronous bus lines.
// Assumes both lines idle high, so reset fills the stages with ones.
module bus_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Each stage re-registers the previous one
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[s] <= '1;
                else if (s == 0) pipe[s] <= d;
                else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/serial_target_fsm.sv
// Byte-level serial bus target: address match, write frame decode,
// single-byte read response and acknowledge driving.
// Assumes synchronised bus levels and bus edges that are many clocks apart.
module serial_target_fsm
    import wiper_otp_pkg::*;
#(
    parameter logic [5:0] ADDR_HI = 6'b010110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              addr_sel,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_oe,
    output logic              wr_en,
    output code_t             wr_code,
    output logic              lock_req,
    output logic              idle
);
    tgt_state_t        state;
    logic              scl_d, sda_d;
    logic [BYTE_W-1:0] shreg;
    logic [3:0]        bitcnt;
    logic [1:0]        idx;
    logic              rw, lock_bit;
    logic              scl_rise, scl_fall, start_det, stop_det;

    // Previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    assign idle      = (state == ST_IDLE);

    // Frame sequencing, byte shifting and acknowledge control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bitcnt   <= '0;
            idx      <= '0;
            rw       <= 1'b0;
            lock_bit <= 1'b0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_code  <= '0;
            lock_req <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state  <= ST_RX;
                bitcnt <= '0;
                idx    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            case (idx)
                                2'd0: begin
                                    if (shreg[7:1] == {ADDR_HI, addr_sel}) begin
                                        rw     <= shreg[0];
                                        state  <= ST_ACK;
                                        sda_oe <= 1'b1;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                2'd1: begin
                                    lock_bit <= shreg[6];
                                    state    <= ST_ACK;
                                    sda_oe   <= 1'b1;
                                end
                                2'd2: begin
                                    wr_en    <= 1'b1;
                                    wr_code  <= shreg[WIPER_W-1:0];
                                    lock_req <= lock_bit;
                                    state    <= ST_ACK;
                                    sda_oe   <= 1'b1;
                                end
                                default: state <= ST_IDLE;
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (rw) begin
                                state  <= ST_TX;
                                shreg  <= rd_byte;
                                sda_oe <= ~rd_byte[BYTE_W-1];
                                bitcnt <= '0;
                            end else begin
                                state  <= ST_RX;
                                sda_oe <= 1'b0;
                                idx    <= idx + 2'd1;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                state  <= ST_RACK;
                                sda_oe <= 1'b0;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[BYTE_W-2];
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_fall) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/otp_lock_unit.sv
// Tap register, one-shot burn timer and reset-immune fuse bank.
// Assumes the fuse bank starts unblown at power-up (declaration values);
// the synchronous reset never touches it.
module otp_lock_unit
    import wiper_otp_pkg::*;
#(
    parameter int BURN_CYCLES = 50_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  code_t       wr_code,
    input  logic        lock_req,
    output code_t       wiper,
    output logic [1:0]  status,
    output logic        busy,
    output logic        fused
);
    localparam int    CNT_W    = $clog2(BURN_CYCLES + 1);
    localparam code_t MIDSCALE = code_t'(1 << (WIPER_W - 1));

    code_t             wiper_q, cap_code;
    logic [CNT_W-1:0]  cnt;
    logic              burn_done;
    logic              fuse_blown = 1'b0;
    logic              fuse_ok    = 1'b0;
    code_t             fuse_code  = '0;

    assign burn_done = busy && (cnt == CNT_W'(BURN_CYCLES - 1));

    // Tap register: preset or fused reload on reset, host writes until fused
    always_ff @(posedge clk) begin
        if (!rst_n) wiper_q <= fuse_blown ? fuse_code : MIDSCALE;
        else if (wr_en && !fuse_blown) wiper_q <= wr_code;
    end

    // Burn timer: one run per lock request, further requests ignored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cnt      <= '0;
            cap_code <= '0;
        end else if (wr_en && lock_req && !busy && !fuse_blown) begin
            busy     <= 1'b1;
            cnt      <= '0;
            cap_code <= wr_code;
        end else if (burn_done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Fuse bank: written once at the end of a burn, kept through reset
    always_ff @(posedge clk) begin
        if (burn_done) begin
            fuse_blown <= 1'b1;
            fuse_code  <= cap_code;
            fuse_ok    <= (cap_code == wiper_q);
        end
    end

    assign wiper  = fuse_blown ? fuse_code : wiper_q;
    assign status = {fuse_blown, fuse_ok};
    assign fused  = fuse_blown;
endmodule

// File: rtl/wiper_otp_target.sv
// Top level: serial target with a lockable 6-bit tap code.
// Assumes clk runs many times faster than the bus clock.
module wiper_otp_target
    import wiper_otp_pkg::*;
#(
    parameter int         BURN_CYCLES = 50_000_000,
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] ADDR_HI     = 6'b010110
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic        addr_sel,
    output logic        sda_oe,
    output logic [5:0]  wiper_o
);
    logic [1:0] bus_s;
    logic       wr_en, lock_req, fsm_idle, burn_busy, fuse_blown;
    code_t      wr_code, wiper;
    logic [1:0] status;

    bus_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s)
    );

    serial_target_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
        .addr_sel(addr_sel), .rd_byte({status, wiper}), .sda_oe(sda_oe),
        .wr_en(wr_en), .wr_code(wr_code), .lock_req(lock_req), .idle(fsm_idle)
    );

    otp_lock_unit #(.BURN_CYCLES(BURN_CYCLES)) u_lock (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code),
        .lock_req(lock_req), .wiper(wiper), .status(status),
        .busy(burn_busy), .fused(fuse_blown)
    );

    assign wiper_o = wiper;
endmodule

// File: rtl/wiper_otp_checker.sv
// Temporal checks on the lockable wiper target, bound into the top.
// Assumes reset is never applied while a burn is running.
module wiper_otp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] wiper_o,
    input logic       sda_oe,
    input logic       fsm_idle,
    input logic       fuse_blown,
    input logic       busy
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_idle |-> !sda_oe); // R9
    AST_FUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_blown |=> fuse_blown); // R7
    AST_FROZEN_WIPER: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_blown |=> $stable(wiper_o)); // R6
    AST_BURN_ENDS_FUSED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> fuse_blown); // R5
    AST_NO_BURN_AFTER_FUSE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !fuse_blown); // R8
endmodule

bind wiper_otp_target wiper_otp_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wiper_o(wiper_o), .sda_oe(sda_oe),
    .fsm_idle(fsm_idle), .fuse_blown(fuse_blown), .busy(burn_busy)
);

// File: tb/wiper_otp_target_bench.sv
module wiper_otp_target_bench;
    localparam int BURN = 3000;
    localparam int H    = 20;
    localparam int Q    = 5;
    localparam logic [6:0] DEV0 = 7'h2C;
    localparam logic [6:0] DEV1 = 7'h2D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic oe0, oe1, sda_bus;
    logic [5:0] w0, w1;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~oe0 & ~oe1;

    wiper_otp_target #(.BURN_CYCLES(BURN)) u_wiper_otp_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .addr_sel(1'b0), .sda_oe(oe0), .wiper_o(w0)
    );

    wiper_otp_target #(.BURN_CYCLES(BURN)) u_wiper_otp_target_b (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .addr_sel(1'b1), .sda_oe(oe1), .wiper_o(w1)
    );

    function automatic logic [7:0] exp_byte(input logic [1:0] st, input logic [5:0] c);
        return {st, c};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_clks(H);
        sda_m = 1'b0; wait_clks(H);
        scl_m = 1'b0; wait_clks(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clks(H);
        scl_m = 1'b1; wait_clks(H);
        sda_m = 1'b1; wait_clks(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clks(H);
            scl_m = 1'b1; wait_clks(H);
            scl_m = 1'b0; wait_clks(Q);
        end
        sda_m = 1'b1; wait_clks(H);
        scl_m = 1'b1; wait_clks(H/2);
        ack = ~sda_bus; wait_clks(H/2);
        scl_m = 1'b0; wait_clks(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_clks(H);
            scl_m = 1'b1; wait_clks(H/2);
            b[i] = sda_bus; wait_clks(H/2);
            scl_m = 1'b0; wait_clks(Q);
        end
        sda_m = 1'b1; wait_clks(H);
        scl_m = 1'b1; wait_clks(H);
        scl_m = 1'b0; wait_clks(Q);
    endtask

    task automatic write_frame(input logic [6:0] a, input logic lk,
                               input logic [5:0] c, output logic ok);
        logic a0, a1, a2;
        a1 = 1'b0; a2 = 1'b0;
        bus_start();
        send_byte({a, 1'b0}, a0);
        if (a0) begin
            send_byte({1'b0, lk, 6'b0}, a1);
            send_byte({2'b00, c}, a2);
        end
        bus_stop();
        ok = a0 & a1 & a2;
    endtask

    task automatic read_frame(input logic [6:0] a, output logic [7:0] b, output logic ack);
        b = 8'h00;
        bus_start();
        send_byte({a, 1'b1}, ack);
        if (ack) recv_byte(b);
        bus_stop();
    endtask

    function automatic logic [6:0] probe_addr(input int sel);
        return (sel == 0) ? DEV0 : DEV1;
    endfunction

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ok;
        logic ack;
        logic [7:0] rb;
        logic [5:0] expw [2];
        logic [5:0] code, kcode, acode, ccode;
        int sel;
        void'($urandom(32'd4242));

        wait_clks(10);
        rst_n = 1'b1;
        wait_clks(5);
        // R1: midscale preset, unlocked status
        chk("R1 dev0 reset code", w0, 6'h20);
        chk("R1 dev1 reset code", w1, 6'h20);
        chk("R9 idle release", {oe0, oe1}, 0);
        read_frame(DEV0, rb, ack);
        chk("R1 read status after reset", rb, exp_byte(2'b00, 6'h20));
        expw[0] = 6'h20; expw[1] = 6'h20;

        // R2/R3/R4: random writes to both targets with read-back
        for (int n = 0; n < 12; n++) begin
            sel  = int'($urandom_range(1, 0));
            code = 6'($urandom_range(63, 0));
            if (n == 0) code = 6'h00;
            if (n == 1) code = 6'h3F;
            write_frame(probe_addr(sel), 1'b0, code, ok);
            expw[sel] = code;
            chk("R2 write acknowledged", ok, 1);
            chk("R2 dev0 code", w0, expw[0]);
            chk("R4 dev1 code", w1, expw[1]);
            read_frame(probe_addr(sel), rb, ack);
            chk("R3 read-back byte", rb, exp_byte(2'b00, expw[sel]));
        end

        // R4: foreign addresses are not acknowledged and change nothing
        for (int n = 0; n < 4; n++) begin
            logic [6:0] bad;
            bad = 7'($urandom_range(127, 0));
            if (bad[6:1] == 6'b010110) bad = 7'h50;
            write_frame(bad, 1'b0, ~expw[0], ok);
            chk("R4 foreign address nack", ok, 0);
            chk("R4 dev0 untouched", w0, expw[0]);
            chk("R4 dev1 untouched", w1, expw[1]);
        end

        // R5: lock dev0 and wait for the burn to complete
        kcode = 6'h2B;
        write_frame(DEV0, 1'b1, kcode, ok);
        chk("R5 lock frame acknowledged", ok, 1);
        chk("R5 code written by lock frame", w0, kcode);
        wait_clks(BURN + 200);
        read_frame(DEV0, rb, ack);
        chk("R5 locked status", rb, exp_byte(2'b11, kcode));

        // R6: writes after locking are acknowledged but ignored
        write_frame(DEV0, 1'b0, 6'h11, ok);
        chk("R6 write still acknowledged", ok, 1);
        chk("R6 frozen code", w0, kcode);
        write_frame(DEV0, 1'b1, 6'h05, ok);
        wait_clks(BURN + 200);
        chk("R6 frozen after relock attempt", w0, kcode);

        // R7: reset reloads fused code, keeps status
        rst_n = 1'b0;
        wait_clks(10);
        rst_n = 1'b1;
        wait_clks(5);
        chk("R7 fused code after reset", w0, kcode);
        chk("R1 unfused dev1 back to midscale", w1, 6'h20);
        read_frame(DEV0, rb, ack);
        chk("R7 status kept after reset", rb, exp_byte(2'b11, kcode));

        // R8: second lock during burn ignored, write lands, lock fails
        acode = 6'h0C; ccode = 6'h31;
        write_frame(DEV1, 1'b1, acode, ok);
        write_frame(DEV1, 1'b1, ccode, ok);
        chk("R8 write during burn lands", w1, ccode);
        read_frame(DEV1, rb, ack);
        chk("R8 status during burn", rb, exp_byte(2'b00, ccode));
        wait_clks(BURN + 200);
        read_frame(DEV1, rb, ack);
        chk("R8 failed lock status", rb, exp_byte(2'b10, acode));
        chk("R8 captured code shown", w1, acode);
        chk("R9 idle release at end", {oe0, oe1}, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule